// File: doc/BRIEF.md
# SDRAM Write Burst Engine

This block is the device-side write path of a synchronous DRAM. It watches a command bus made of a chip select, a clock enable and three active-low strobes (row strobe, column strobe, write enable), together with a bank select and an address bus. It keeps an open/closed flag per bank and a burst-length setting. When a write arrives for an open bank, it steers the data words into a small banked register array that stands in for the memory cells. It produces one column address per clock for fixed-length or full-page bursts. A new write may cut into a running burst on any cycle. When a burst that asked for auto-precharge finishes, the block raises a per-bank precharge flag.

A peek port reads the array combinationally, so its contents can be observed at the ports. An error pulse reports a write aimed at a bank with no open row.

Top module: `sdram_wr_engine`

## Requirements
- R1: A command is decoded only with `clk_en`=1 and `chip_sel_n`=0. A WRITE is {row_strobe_n, col_strobe_n, wr_enable_n} = 1,0,0. When the WRITE targets an open bank, its `data_in` word is stored at column `addr_in[7:0]` of bank `bank_sel` on the same rising edge as the command. Later burst words are stored on the following edges.
- R2: A mode-set command (all three strobes 0) loads the burst-length code from `addr_in[2:0]`: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. Codes 4 to 6 leave the setting unchanged. Reset selects 1 word. The length is latched when a WRITE starts, so a later mode-set does not change a running burst.
- R3: In a fixed burst of length L, word i goes to column (start & ~(L-1)) | ((start+i) & (L-1)). The address wraps inside the L-aligned block.
- R4: Once a fixed burst has stored its last word, `data_in` is ignored until the next accepted WRITE.
- R5: A full-page burst steps the column by one per word, wraps from 255 to 0, and runs until a new WRITE truncates it.
- R6: A WRITE accepted while a burst runs ends that burst at once. The word presented with the new command belongs to the new burst. WRITEs may be issued on every cycle, to any bank and column.
- R7: `mask_in`=1 on a data cycle suppresses the store of that word, but the burst still advances to its next column.
- R8: Deselect (`chip_sel_n`=1), no-op (1,1,1) and the other unused encodings leave a running burst going, and it keeps storing words. With `clk_en`=0, no command is decoded and the burst neither stores nor advances.
- R9: A WRITE to a closed bank stores nothing and does not disturb a running burst, which takes that cycle's word. `err_o` is high for exactly the cycle after that edge.
- R10: ACTIVATE (0,1,1) opens bank `bank_sel`. PRECHARGE (0,1,0) closes bank `bank_sel`, or every bank when `addr_in[10]`=1.
- R11: A WRITE with `addr_in[10]`=1 requests auto-precharge. On the edge that stores the burst's last word, that bank closes and `prech_o[bank]` is high for the next cycle. If such a burst is truncated by a WRITE to another bank, the same happens on the truncating edge. If the truncating WRITE targets the same bank, the precharge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock enable; low freezes decode and bursts |
| chip_sel_n | input | 1 | Active-low chip select |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| wr_enable_n | input | 1 | Write enable strobe, active low |
| bank_sel | input | 2 | Bank address |
| addr_in | input | 11 | Column in [7:0], length code in [2:0], auto-precharge / all-banks in [10] |
| mask_in | input | 1 | Word mask for the current data cycle |
| data_in | input | 16 | Write data word |
| prech_o | output | 4 | Per-bank auto-precharge pulse |
| err_o | output | 1 | Pulse: write to a bank with no open row |
| peek_bank | input | 2 | Array observation bank |
| peek_col | input | 8 | Array observation column |
| peek_data | output | 16 | Array word at the peek address |

## Verification
Some internal faults corrupt the storage: a stale burst counter, a wrong column wrap or a lost truncation. These put words in the wrong cells or miss cells. A full sweep of the peek port after each scenario shows this, as soon as the scenario's bursts have settled. Faults in the bank-open bookkeeping or the auto-precharge logic show up one cycle after the deciding edge, as a wrong or missing pulse on `prech_o` or `err_o`. Later, a write that is wrongly accepted or wrongly refused leaves a visible difference in the array.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_ACT,
      CMD_WR,
      CMD_PRE,
      CMD_MODE,
      CMD_OTHER
   } cmd_e;

   localparam logic [2:0] BLC_1    = 3'd0;
   localparam logic [2:0] BLC_2    = 3'd1;
   localparam logic [2:0] BLC_4    = 3'd2;
   localparam logic [2:0] BLC_8    = 3'd3;
   localparam logic [2:0] BLC_PAGE = 3'd7;

   function automatic logic code_legal(input logic [2:0] code);
      return (code == BLC_1) || (code == BLC_2) || (code == BLC_4) ||
             (code == BLC_8) || (code == BLC_PAGE);
   endfunction

   function automatic cmd_e strobe_decode(input logic r_n, input logic c_n, input logic w_n);
      case ({r_n, c_n, w_n})
         3'b111:  return CMD_NOP;
         3'b011:  return CMD_ACT;
         3'b100:  return CMD_WR;
         3'b010:  return CMD_PRE;
         3'b000:  return CMD_MODE;
         default: return CMD_OTHER;
      endcase
   endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_wr_pkg::*;
(
   input  logic clk_en,
   input  logic chip_sel_n,
   input  logic row_strobe_n,
   input  logic col_strobe_n,
   input  logic wr_enable_n,
   output cmd_e cmd
);

   always_comb begin
      if (!clk_en || chip_sel_n)
         cmd = CMD_NOP;
      else
         cmd = strobe_decode(row_strobe_n, col_strobe_n, wr_enable_n);
   end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
   import sdram_wr_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int COL_BITS  = 8,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv_en,
   input  logic                 wr_go,
   input  logic [BA_W-1:0]      wr_bank,
   input  logic [COL_BITS-1:0]  wr_col,
   input  logic                 wr_ap,
   input  logic [2:0]           bl_code,
   output logic                 slot_en,
   output logic [BA_W-1:0]      slot_bank,
   output logic [COL_BITS-1:0]  slot_col,
   output logic [NUM_BANKS-1:0] ap_close
);

   logic                run_q;
   logic                full_q;
   logic                ap_q;
   logic [BA_W-1:0]     bank_q;
   logic [COL_BITS-1:0] base_q;
   logic [COL_BITS-1:0] cnt_q;
   logic [COL_BITS-1:0] mask_q;

   logic [COL_BITS-1:0] new_mask;
   logic                new_full;
   logic                new_single;
   logic [COL_BITS-1:0] run_col;
   logic                run_last;

   always_comb begin
      new_full = 1'b0;
      case (bl_code)
         BLC_1:   new_mask = '0;
         BLC_2:   new_mask = COL_BITS'(1);
         BLC_4:   new_mask = COL_BITS'(3);
         BLC_8:   new_mask = COL_BITS'(7);
         default: begin
            new_mask = '1;
            new_full = 1'b1;
         end
      endcase
   end

   assign new_single = !new_full && (new_mask == '0);
   assign run_col    = (base_q & ~mask_q) | ((base_q + cnt_q) & mask_q);
   assign run_last   = run_q && !full_q && (cnt_q == mask_q);

   always_comb begin
      slot_en   = 1'b0;
      slot_bank = bank_q;
      slot_col  = run_col;
      ap_close  = '0;
      if (adv_en) begin
         if (wr_go) begin
            slot_en   = 1'b1;
            slot_bank = wr_bank;
            slot_col  = wr_col;
            if (new_single && wr_ap)
               ap_close[wr_bank] = 1'b1;
            if (run_q && ap_q && (bank_q != wr_bank))
               ap_close[bank_q] = 1'b1;
         end else if (run_q) begin
            slot_en = 1'b1;
            if (run_last && ap_q)
               ap_close[bank_q] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         full_q <= 1'b0;
         ap_q   <= 1'b0;
         bank_q <= '0;
         base_q <= '0;
         cnt_q  <= '0;
         mask_q <= '0;
      end else if (adv_en) begin
         if (wr_go) begin
            run_q  <= !new_single;
            full_q <= new_full;
            ap_q   <= wr_ap;
            bank_q <= wr_bank;
            base_q <= wr_col;
            cnt_q  <= COL_BITS'(1);
            mask_q <= new_mask;
         end else if (run_q) begin
            if (run_last)
               run_q <= 1'b0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
   parameter int NUM_BANKS = 4,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 act_en,
   input  logic                 pre_en,
   input  logic                 pre_all,
   input  logic [BA_W-1:0]      cmd_bank,
   input  logic [NUM_BANKS-1:0] ap_close,
   output logic [NUM_BANKS-1:0] open_q,
   output logic [NUM_BANKS-1:0] prech_o
);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic open_r;
      logic pulse_r;
      logic hit;

      assign hit = (cmd_bank == BA_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_r  <= 1'b0;
            pulse_r <= 1'b0;
         end else begin
            pulse_r <= ap_close[b];
            if (act_en && hit)
               open_r <= 1'b1;
            else if ((pre_en && (pre_all || hit)) || ap_close[b])
               open_r <= 1'b0;
         end
      end

      assign open_q[b]  = open_r;
      assign prech_o[b] = pulse_r;
   end

endmodule

// File: rtl/sdram_bank_array.sv
module sdram_bank_array #(
   parameter int DATA_W    = 16,
   parameter int NUM_BANKS = 4,
   parameter int COL_BITS  = 8,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int DEPTH    = 1 << COL_BITS
) (
   input  logic                clk,
   input  logic                we,
   input  logic [BA_W-1:0]     wr_bank,
   input  logic [COL_BITS-1:0] wr_col,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [BA_W-1:0]     peek_bank,
   input  logic [COL_BITS-1:0] peek_col,
   output logic [DATA_W-1:0]   peek_data
);

   logic [DATA_W-1:0] rd_word [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we && (wr_bank == BA_W'(b)))
            cells[wr_col] <= wr_data;
      end

      assign rd_word[b] = cells[peek_col];
   end

   assign peek_data = rd_word[peek_bank];

endmodule

// File: rtl/sdram_wr_engine.sv
module sdram_wr_engine
   import sdram_wr_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int NUM_BANKS = 4,
   parameter int COL_BITS  = 8,
   parameter int ADDR_W    = 11,
   parameter int AP_BIT    = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clk_en,
   input  logic                         chip_sel_n,
   input  logic                         row_strobe_n,
   input  logic                         col_strobe_n,
   input  logic                         wr_enable_n,
   input  logic [$clog2(NUM_BANKS)-1:0] bank_sel,
   input  logic [ADDR_W-1:0]            addr_in,
   input  logic                         mask_in,
   input  logic [DATA_W-1:0]            data_in,
   output logic [NUM_BANKS-1:0]         prech_o,
   output logic                         err_o,
   input  logic [$clog2(NUM_BANKS)-1:0] peek_bank,
   input  logic [COL_BITS-1:0]          peek_col,
   output logic [DATA_W-1:0]            peek_data
);

   localparam int BA_W = $clog2(NUM_BANKS);

   if (COL_BITS < 3 || COL_BITS > AP_BIT) begin : g_bad_col
      $error("COL_BITS must lie between 3 and AP_BIT");
   end
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (ADDR_W <= AP_BIT) begin : g_bad_addr
      $error("ADDR_W must exceed AP_BIT");
   end

   if (AP_BIT > COL_BITS) begin : g_spare
      logic unused_addr_bits;
      assign unused_addr_bits = ^addr_in[AP_BIT-1:COL_BITS];
   end
   if (ADDR_W > AP_BIT + 1) begin : g_spare_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr_in[ADDR_W-1:AP_BIT+1];
   end

   cmd_e                 cmd;
   logic [2:0]           bl_code_q;
   logic [NUM_BANKS-1:0] bank_open;
   logic [NUM_BANKS-1:0] ap_close;
   logic                 wr_req;
   logic                 wr_go;
   logic                 err_q;
   logic                 slot_en;
   logic [BA_W-1:0]      slot_bank;
   logic [COL_BITS-1:0]  slot_col;

   sdram_cmd_decode u_dec (
      .clk_en       (clk_en),
      .chip_sel_n   (chip_sel_n),
      .row_strobe_n (row_strobe_n),
      .col_strobe_n (col_strobe_n),
      .wr_enable_n  (wr_enable_n),
      .cmd          (cmd)
   );

   assign wr_req = (cmd == CMD_WR);
   assign wr_go  = wr_req && bank_open[bank_sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bl_code_q <= BLC_1;
         err_q     <= 1'b0;
      end else begin
         err_q <= wr_req && !bank_open[bank_sel];
         if (cmd == CMD_MODE && code_legal(addr_in[2:0]))
            bl_code_q <= addr_in[2:0];
      end
   end

   assign err_o = err_q;

   sdram_burst_seq #(
      .NUM_BANKS (NUM_BANKS),
      .COL_BITS  (COL_BITS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_en    (clk_en),
      .wr_go     (wr_go),
      .wr_bank   (bank_sel),
      .wr_col    (addr_in[COL_BITS-1:0]),
      .wr_ap     (addr_in[AP_BIT]),
      .bl_code   (bl_code_q),
      .slot_en   (slot_en),
      .slot_bank (slot_bank),
      .slot_col  (slot_col),
      .ap_close  (ap_close)
   );

   sdram_bank_state #(
      .NUM_BANKS (NUM_BANKS)
   ) u_bst (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_en   (cmd == CMD_ACT),
      .pre_en   (cmd == CMD_PRE),
      .pre_all  (addr_in[AP_BIT]),
      .cmd_bank (bank_sel),
      .ap_close (ap_close),
      .open_q   (bank_open),
      .prech_o  (prech_o)
   );

   sdram_bank_array #(
      .DATA_W    (DATA_W),
      .NUM_BANKS (NUM_BANKS),
      .COL_BITS  (COL_BITS)
   ) u_arr (
      .clk       (clk),
      .we        (slot_en && !mask_in),
      .wr_bank   (slot_bank),
      .wr_col    (slot_col),
      .wr_data   (data_in),
      .peek_bank (peek_bank),
      .peek_col  (peek_col),
      .peek_data (peek_data)
   );

endmodule

// File: rtl/sdram_wr_engine_chk.sv
module sdram_wr_engine_chk #(
   parameter int DATA_W    = 16,
   parameter int NUM_BANKS = 4,
   parameter int COL_BITS  = 8,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 clk_en,
   input logic                 chip_sel_n,
   input logic                 err_o,
   input logic [NUM_BANKS-1:0] prech_o,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic [2:0]           bl_code_q,
   input logic [BA_W-1:0]      peek_bank,
   input logic [COL_BITS-1:0]  peek_col,
   input logic [DATA_W-1:0]    peek_data
);

   // R9
   no_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_sel_n || !clk_en) |=> !err_o);

   // R11
   prech_from_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|prech_o) |-> ((prech_o & $past(bank_open)) == prech_o));

   // R11
   prech_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|prech_o) |-> ((prech_o & bank_open) == '0));

   // R2
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bl_code_q inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7});

   // R8
   freeze_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> (!$stable(peek_bank) || !$stable(peek_col) || $stable(peek_data)));

endmodule

bind sdram_wr_engine sdram_wr_engine_chk #(
   .DATA_W    (DATA_W),
   .NUM_BANKS (NUM_BANKS),
   .COL_BITS  (COL_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_en     (clk_en),
   .chip_sel_n (chip_sel_n),
   .err_o      (err_o),
   .prech_o    (prech_o),
   .bank_open  (bank_open),
   .bl_code_q  (bl_code_q),
   .peek_bank  (peek_bank),
   .peek_col   (peek_col),
   .peek_data  (peek_data)
);

// File: tb/tb_sdram_wr_engine.sv
`timescale 1ns/1ps
module tb_sdram_wr_engine;

   localparam int PAGE = 256;
   localparam int NB   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en = 1'b1;
   logic        chip_sel_n = 1'b1;
   logic        row_strobe_n = 1'b1;
   logic        col_strobe_n = 1'b1;
   logic        wr_enable_n = 1'b1;
   logic [1:0]  bank_sel = '0;
   logic [10:0] addr_in = '0;
   logic        mask_in = 1'b0;
   logic [15:0] data_in = '0;
   logic [3:0]  prech_o;
   logic        err_o;
   logic [1:0]  peek_bank = '0;
   logic [7:0]  peek_col = '0;
   logic [15:0] peek_data;

   always #5 clk = ~clk;

   sdram_wr_engine dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel_n(chip_sel_n),
      .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .wr_enable_n(wr_enable_n),
      .bank_sel(bank_sel), .addr_in(addr_in), .mask_in(mask_in), .data_in(data_in),
      .prech_o(prech_o), .err_o(err_o),
      .peek_bank(peek_bank), .peek_col(peek_col), .peek_data(peek_data)
   );

   int n_chk = 0;
   int n_fail = 0;

   logic [15:0] mem_m [NB*PAGE];
   bit          open_m [NB];
   logic [2:0]  code_m = 3'd0;
   bit          b_act = 0, b_full = 0, b_ap = 0;
   int          b_bank = 0, b_base = 0, b_idx = 0, b_mask = 0;
   logic [3:0]  exp_prech = '0;
   bit          exp_err = 0;
   logic [15:0] dv = 16'h1234;

   function automatic logic [15:0] nd();
      dv = dv * 16'd5 + 16'h3b1;
      return dv;
   endfunction

   function automatic int mask_of(input logic [2:0] c);
      case (c)
         3'd0: return 0;
         3'd1: return 1;
         3'd2: return 3;
         3'd3: return 7;
         default: return 255;
      endcase
   endfunction

   function automatic int col_at(input int base, input int idx, input int m);
      return ((base & ~m) | ((base + idx) & m)) & 255;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic cycle(input string tag);
      @(posedge clk);
      @(negedge clk);
      chk(tag, "prech_o", 32'(prech_o), 32'(exp_prech));
      chk(tag, "err_o", 32'(err_o), 32'(exp_err));
      exp_prech = '0;
      exp_err = 0;
   endtask

   task automatic drive(input bit c, input bit r, input bit ca, input bit w,
                        input int bank, input int a, input logic [15:0] d, input bit m);
      chip_sel_n = c; row_strobe_n = r; col_strobe_n = ca; wr_enable_n = w;
      bank_sel = 2'(bank); addr_in = 11'(a); data_in = d; mask_in = m;
   endtask

   // model of one data cycle of a running burst
   task automatic m_data(input logic [15:0] d, input bit m);
      if (b_act) begin
         if (!m) mem_m[b_bank*PAGE + col_at(b_base, b_idx, b_mask)] = d;
         if (!b_full && b_idx == b_mask) begin
            b_act = 0;
            if (b_ap) begin exp_prech[b_bank] = 1'b1; open_m[b_bank] = 0; end
         end else begin
            b_idx = (b_idx + 1) % PAGE;
         end
      end
   endtask

   task automatic nop(input string tag, input bit m);
      logic [15:0] d = nd();
      drive(0, 1, 1, 1, 0, 0, d, m); m_data(d, m); cycle(tag);
   endtask

   task automatic desel(input string tag);
      logic [15:0] d = nd();
      drive(1, 1, 0, 0, 1, 0, d, 0); m_data(d, 0); cycle(tag);
   endtask

   task automatic other(input string tag, input bit r, input bit ca, input bit w);
      logic [15:0] d = nd();
      drive(0, r, ca, w, 0, 0, d, 0); m_data(d, 0); cycle(tag);
   endtask

   task automatic susp(input string tag);
      clk_en = 1'b0;
      drive(0, 1, 0, 0, 0, 5, nd(), 0);
      cycle(tag);
      clk_en = 1'b1;
   endtask

   task automatic act(input string tag, input int bank);
      logic [15:0] d = nd();
      drive(0, 0, 1, 1, bank, 0, d, 0); m_data(d, 0); open_m[bank] = 1; cycle(tag);
   endtask

   task automatic pre(input string tag, input int bank, input bit all);
      logic [15:0] d = nd();
      drive(0, 0, 1, 0, bank, all ? 1024 : 0, d, 0); m_data(d, 0);
      for (int b = 0; b < NB; b++) if (all || b == bank) open_m[b] = 0;
      cycle(tag);
   endtask

   task automatic mrs(input string tag, input int code);
      logic [15:0] d = nd();
      drive(0, 0, 0, 0, 0, code, d, 0); m_data(d, 0);
      if (code inside {0, 1, 2, 3, 7}) code_m = 3'(code);
      cycle(tag);
   endtask

   task automatic wr(input string tag, input int bank, input int col, input bit ap, input bit m);
      logic [15:0] d = nd();
      drive(0, 1, 0, 0, bank, (ap ? 1024 : 0) + col, d, m);
      if (!open_m[bank]) begin
         exp_err = 1;
         m_data(d, m);
      end else begin
         if (b_act && b_ap && b_bank != bank) begin
            exp_prech[b_bank] = 1'b1; open_m[b_bank] = 0;
         end
         b_mask = mask_of(code_m); b_full = (code_m == 3'd7);
         b_bank = bank; b_base = col; b_ap = ap; b_idx = 1;
         if (!m) mem_m[bank*PAGE + col] = d;
         b_act = (b_mask != 0);
         if (!b_act && ap) begin exp_prech[bank] = 1'b1; open_m[bank] = 0; end
      end
      cycle(tag);
   endtask

   task automatic sweep(input string tag);
      clk_en = 1'b0; chip_sel_n = 1'b1;
      for (int b = 0; b < NB; b++) begin
         for (int c = 0; c < PAGE; c++) begin
            peek_bank = 2'(b); peek_col = 8'(c);
            #1;
            chk(tag, $sformatf("cell b%0d c%0d", b, c), 32'(peek_data), 32'(mem_m[b*PAGE + c]));
         end
      end
      @(negedge clk);
      clk_en = 1'b1;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11", "reset prech_o", 32'(prech_o), 32'd0);
      chk("R9", "reset err_o", 32'(err_o), 32'd0);
      rst_n = 1'b1;

      // R10 open all banks, R5 fill every page with full-page bursts
      for (int b = 0; b < NB; b++) act("R10", b);
      mrs("R2", 7);
      for (int b = 0; b < NB; b++) begin
         wr("R5", b, 0, 0, 0);
         for (int c = 1; c < PAGE; c++) nop("R5", 0);
      end
      mrs("R2", 0);
      wr("R1", 3, 0, 0, 0);
      sweep("R1");

      // R3 R4 fixed lengths, starts across an aligned block, extra data ignored
      for (int code = 0; code < 4; code++) begin
         mrs("R2", code);
         for (int s = 0; s < 16; s++) begin
            wr("R3", s % NB, 32*code + 64 + s, 0, 0);
            for (int k = 0; k < (1 << code) + 1; k++) nop("R4", 0);
         end
      end
      sweep("R3 R4");

      // R5 wrap 255 -> 0, R2 mode change mid-burst does not alter it
      mrs("R2", 7);
      wr("R5", 2, 250, 0, 0);
      for (int k = 0; k < 9; k++) nop("R5", 0);
      mrs("R2", 0);
      nop("R2", 0); nop("R2", 0);
      wr("R5", 2, 100, 0, 0);
      nop("R4", 0); nop("R4", 0);
      sweep("R5 R2");

      // R6 one write per clock, any bank, and truncation
      mrs("R2", 3);
      for (int i = 0; i < 20; i++) wr("R6", (i*3) % NB, (i*37) % PAGE, 0, 0);
      wr("R6", 1, 64, 0, 0);
      for (int k = 0; k < 3; k++) nop("R6", 0);
      wr("R6", 0, 70, 0, 0);
      for (int k = 0; k < 9; k++) nop("R6", 0);
      sweep("R6");

      // R7 masked words still advance the burst
      mrs("R2", 2);
      wr("R7", 3, 202, 0, 1);
      nop("R7", 0); nop("R7", 1); nop("R7", 0); nop("R7", 0);
      mrs("R2", 7);
      wr("R7", 1, 254, 0, 0);
      nop("R7", 1); nop("R7", 0); nop("R7", 1);
      mrs("R2", 0);
      wr("R7", 1, 9, 0, 1);
      sweep("R7");

      // R8 deselect, unused encodings, clock-enable low
      mrs("R2", 3);
      wr("R8", 0, 130, 0, 0);
      nop("R8", 0);
      desel("R8");
      other("R8", 1, 0, 1);
      other("R8", 0, 0, 1);
      susp("R8"); susp("R8");
      for (int k = 0; k < 6; k++) nop("R8", 0);
      sweep("R8");

      // R9 R10 closed banks
      pre("R10", 1, 0);
      mrs("R2", 2);
      wr("R9", 0, 40, 0, 0);
      wr("R9", 1, 50, 0, 0);
      for (int k = 0; k < 4; k++) nop("R9", 0);
      pre("R10", 0, 1);
      wr("R9", 3, 9, 0, 0);
      wr("R9", 0, 9, 0, 0);
      for (int b = 0; b < NB; b++) act("R10", b);
      wr("R10", 2, 11, 0, 0);
      for (int k = 0; k < 4; k++) nop("R10", 0);
      sweep("R9 R10");

      // R11 auto-precharge at end, at truncation, dropped for same bank, single word
      mrs("R2", 1);
      wr("R11", 0, 10, 1, 0);
      nop("R11", 0); nop("R11", 0);
      wr("R11", 0, 12, 0, 0);
      act("R11", 0);
      mrs("R2", 3);
      wr("R11", 1, 20, 1, 0);
      nop("R11", 0); nop("R11", 0);
      wr("R11", 2, 30, 0, 0);
      for (int k = 0; k < 8; k++) nop("R11", 0);
      act("R11", 1);
      wr("R11", 2, 40, 1, 0);
      nop("R11", 0);
      wr("R11", 2, 44, 0, 0);
      for (int k = 0; k < 8; k++) nop("R11", 0);
      mrs("R2", 0);
      wr("R11", 3, 5, 1, 0);
      nop("R11", 0);
      wr("R11", 3, 6, 0, 0);
      act("R11", 3);
      wr("R11", 2, 45, 0, 0);
      sweep("R11");

      // R2 illegal length codes keep the old setting
      mrs("R2", 2);
      mrs("R2", 5);
      wr("R2", 1, 81, 0, 0);
      for (int k = 0; k < 5; k++) nop("R2", 0);
      mrs("R2", 6);
      wr("R2", 2, 90, 0, 0);
      for (int k = 0; k < 5; k++) nop("R2", 0);
      sweep("R2");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule